// File: doc/BRIEF.md
# Configurable Registered Memory-Address Buffer

This block is a single clocked register stage that sits between a memory controller and the devices on a registered memory module. On every rising clock edge it captures the command and address bits and re-drives them. Two static configuration inputs set its shape. With `fanout_en` low it is a 25-bit register that maps each input straight through. With `fanout_en` high it is a 14-bit register, and each captured bit drives two output copies: the A copy on `q_a` and the B copy on `q_b`. In that two-copy mode, `alt_map` selects which group of 14 inputs is used.

The clock-enable and on-die-termination bits have their own registered outputs. In two-copy mode each of them also gets an A copy and a B copy. Two active-low select inputs can freeze the data outputs: when both are high at a clock edge, `q_a` and `q_b` keep their values. The clock-enable and termination outputs keep updating while the data outputs are frozen. An asynchronous active-low reset clears every register at once, and the select gating has no effect on it.

Top module: `regbuf_fanout`

## Requirements
- R1: While `rst_n` is low, every output is 0, and it is 0 immediately after `rst_n` falls, without waiting for a clock edge.
- R2: With `fanout_en`=0 and the data not frozen, one rising edge after the inputs are applied `q_a` equals `din`, `cke_a`/`odt_a` equal `cke_in`/`odt_in`, and `q_b`, `cke_b` and `odt_b` are 0.
- R3: With `fanout_en`=1 and `alt_map`=0, one edge later `q_a[13:0]` and `q_b` both equal `din[13:0]`.
- R4: With `fanout_en`=1 and `alt_map`=1, one edge later `q_a[13:0]` and `q_b` both equal `din[24:11]`.
- R5: In two-copy mode the data inputs outside the selected group have no effect on any output: `din[24:14]` for `alt_map`=0, and `din[10:0]` for `alt_map`=1.
- R6: When `csel_n` and `csel_aux_n` are both 1 at a rising edge and the configuration is unchanged, `q_a` and `q_b` keep their values.
- R7: When `csel_n` or `csel_aux_n` is 0 at a rising edge, the data outputs update from `din` as in R2 to R4.
- R8: `cke_a`/`odt_a` (and in two-copy mode also `cke_b`/`odt_b`) follow `cke_in`/`odt_in` one edge later, whatever the select inputs are.
- R9: Reset clears the outputs even while the data outputs are frozen. Frozen edges that follow reset keep the outputs at 0.
- R10: Outputs that the current mode does not use are 0 after every edge, frozen or not: `q_a[24:14]` in two-copy mode, and `q_b`, `cke_b`, `odt_b` in 25-bit mode.
- R11: After reset is released, all outputs stay 0 until an edge captures non-zero inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fanout_en | input | 1 | 0: 25-bit 1:1 mode, 1: 14-bit 1:2 mode |
| alt_map | input | 1 | Two-copy input group: 0 = din[13:0], 1 = din[24:11] |
| csel_n | input | 1 | First select; data frozen when this and csel_aux_n are both 1 |
| csel_aux_n | input | 1 | Second select; data frozen when this and csel_n are both 1 |
| cke_in | input | 1 | Clock-enable bit to register |
| odt_in | input | 1 | Termination-control bit to register |
| din | input | 25 | Command/address data inputs |
| q_a | output | 25 | Registered data, A copy (all 25 bits in 1:1 mode) |
| q_b | output | 14 | Registered data, B copy (two-copy mode only) |
| cke_a | output | 1 | Registered clock enable, A copy |
| cke_b | output | 1 | Registered clock enable, B copy |
| odt_a | output | 1 | Registered termination control, A copy |
| odt_b | output | 1 | Registered termination control, B copy |

## Verification
Every data and control result is due exactly one rising edge after the inputs that produce it are present. The one exception is reset: its clearing shows on the outputs before any edge. The driver applies inputs on a falling edge, and at the next rising edge it pushes the expected outputs into a queue. The monitor compares them on the falling edge that follows, so each comparison sits half a cycle away from the edge that updates the outputs. The reset cases are checked directly, a nanosecond after `rst_n` falls and while the clock is idle between edges.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    typedef enum logic [1:0] {
        MAP_WIDE   = 2'd0,
        MAP_PAIR_A = 2'd1,
        MAP_PAIR_B = 2'd2
    } map_e;

    function automatic map_e decode_map(input logic fanout_en, input logic alt_map);
        if (!fanout_en)
            return MAP_WIDE;
        return alt_map ? MAP_PAIR_B : MAP_PAIR_A;
    endfunction

endpackage

// File: rtl/regbuf_lane_pick.sv
module regbuf_lane_pick #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  logic [WIDE_W-1:0]   din,
    input  logic                alt_map,
    output logic [NARROW_W-1:0] pick
);
    localparam int OFS = WIDE_W - NARROW_W;

    for (genvar i = 0; i < NARROW_W; i++) begin : g_lane
        assign pick[i] = alt_map ? din[i + OFS] : din[i];
    end
endmodule

// File: rtl/regbuf_fanout_map.sv
module regbuf_fanout_map
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  map_e                mode,
    input  logic [WIDE_W-1:0]   din,
    input  logic [NARROW_W-1:0] pick,
    input  logic                cke_in,
    input  logic                odt_in,
    output logic [WIDE_W-1:0]   fresh_a,
    output logic [NARROW_W-1:0] fresh_b,
    output logic [1:0]          fresh_cke,
    output logic [1:0]          fresh_odt
);
    localparam int OFS = WIDE_W - NARROW_W;

    always_comb begin
        if (mode == MAP_WIDE) begin
            fresh_a   = din;
            fresh_b   = '0;
            fresh_cke = {1'b0, cke_in};
            fresh_odt = {1'b0, odt_in};
        end else begin
            fresh_a   = {{OFS{1'b0}}, pick};
            fresh_b   = pick;
            fresh_cke = {cke_in, cke_in};
            fresh_odt = {odt_in, odt_in};
        end
    end
endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fanout_en,
    input  logic                alt_map,
    input  logic                csel_n,
    input  logic                csel_aux_n,
    input  logic                cke_in,
    input  logic                odt_in,
    input  logic [WIDE_W-1:0]   din,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b,
    output logic                cke_a,
    output logic                cke_b,
    output logic                odt_a,
    output logic                odt_b
);
    localparam int OFS = WIDE_W - NARROW_W;
    localparam logic [WIDE_W-1:0] LOW_LANES = {{OFS{1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [WIDE_W-1:0]   qa;
        logic [NARROW_W-1:0] qb;
        logic [1:0]          cke;
        logic [1:0]          odt;
    } stage_t;

    stage_t stage_d, stage_q;
    map_e   mode;

    logic [NARROW_W-1:0] pick;
    logic [WIDE_W-1:0]   fresh_a;
    logic [NARROW_W-1:0] fresh_b;
    logic [1:0]          fresh_cke, fresh_odt;
    logic                freeze;

    assign mode   = decode_map(fanout_en, alt_map);
    assign freeze = csel_n & csel_aux_n;

    regbuf_lane_pick #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_pick (
        .din     (din),
        .alt_map (alt_map),
        .pick    (pick)
    );

    regbuf_fanout_map #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_map (
        .mode      (mode),
        .din       (din),
        .pick      (pick),
        .cke_in    (cke_in),
        .odt_in    (odt_in),
        .fresh_a   (fresh_a),
        .fresh_b   (fresh_b),
        .fresh_cke (fresh_cke),
        .fresh_odt (fresh_odt)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.cke = fresh_cke;
        stage_d.odt = fresh_odt;
        if (freeze) begin
            // hold data, but lanes unused in the current mode go low
            if (mode == MAP_WIDE) begin
                stage_d.qa = stage_q.qa;
                stage_d.qb = '0;
            end else begin
                stage_d.qa = stage_q.qa & LOW_LANES;
                stage_d.qb = stage_q.qb;
            end
        end else begin
            stage_d.qa = fresh_a;
            stage_d.qb = fresh_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign q_a   = stage_q.qa;
    assign q_b   = stage_q.qb;
    assign cke_a = stage_q.cke[0];
    assign cke_b = stage_q.cke[1];
    assign odt_a = stage_q.odt[0];
    assign odt_b = stage_q.odt[1];
endmodule

// File: rtl/regbuf_fanout_chk.sv
module regbuf_fanout_chk #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fanout_en,
    input logic                alt_map,
    input logic                csel_n,
    input logic                csel_aux_n,
    input logic                cke_in,
    input logic                odt_in,
    input logic [WIDE_W-1:0]   din,
    input logic [WIDE_W-1:0]   q_a,
    input logic [NARROW_W-1:0] q_b,
    input logic                cke_a,
    input logic                cke_b,
    input logic                odt_a,
    input logic                odt_b
);
    localparam int OFS = WIDE_W - NARROW_W;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !cke_a && !cke_b && !odt_a && !odt_b));

    // R2
    wide_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fanout_en) && !($past(csel_n) && $past(csel_aux_n)))
        |-> (q_a == $past(din) && q_b == '0));

    // R4
    alt_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fanout_en) && $past(alt_map) && !($past(csel_n) && $past(csel_aux_n)))
        |-> (q_b == $past(din[WIDE_W-1:OFS]) && q_a[NARROW_W-1:0] == $past(din[WIDE_W-1:OFS])));

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(csel_n) && $past(csel_aux_n)
         && $past(fanout_en) == $past(fanout_en, 2) && $past(alt_map) == $past(alt_map, 2))
        |-> ($stable(q_a) && $stable(q_b)));

    // R8
    ctl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cke_a == $past(cke_in) && odt_a == $past(odt_in)));

    // R10
    pair_upper_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fanout_en)) |-> (q_a[WIDE_W-1:NARROW_W] == '0));

    // R10
    wide_copy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fanout_en)) |-> (q_b == '0 && !cke_b && !odt_b));
endmodule

bind regbuf_fanout regbuf_fanout_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fanout_en  (fanout_en),
    .alt_map    (alt_map),
    .csel_n     (csel_n),
    .csel_aux_n (csel_aux_n),
    .cke_in     (cke_in),
    .odt_in     (odt_in),
    .din        (din),
    .q_a        (q_a),
    .q_b        (q_b),
    .cke_a      (cke_a),
    .cke_b      (cke_b),
    .odt_a      (odt_a),
    .odt_b      (odt_b)
);

// File: tb/regbuf_fanout_test.sv
module regbuf_fanout_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        fanout_en = 1'b0, alt_map = 1'b0;
    logic        csel_n = 1'b0, csel_aux_n = 1'b0;
    logic        cke_in = 1'b0, odt_in = 1'b0;
    logic [24:0] din = '0;
    logic [24:0] q_a;
    logic [13:0] q_b;
    logic        cke_a, cke_b, odt_a, odt_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [24:0] a;
        logic [13:0] b;
        logic [3:0]  ctl;   // {odt_b, odt_a, cke_b, cke_a}
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [24:0] m_a   = '0;
    logic [13:0] m_b   = '0;
    logic [3:0]  m_ctl = '0;

    always #5 clk = ~clk;

    regbuf_fanout uut (
        .clk(clk), .rst_n(rst_n), .fanout_en(fanout_en), .alt_map(alt_map),
        .csel_n(csel_n), .csel_aux_n(csel_aux_n), .cke_in(cke_in), .odt_in(odt_in),
        .din(din), .q_a(q_a), .q_b(q_b), .cke_a(cke_a), .cke_b(cke_b),
        .odt_a(odt_a), .odt_b(odt_b)
    );

    task automatic compare(string tag, logic [24:0] ea, logic [13:0] eb, logic [3:0] ec);
        logic [3:0] ac;
        ac = {odt_b, odt_a, cke_b, cke_a};
        checks++;
        if (q_a !== ea || q_b !== eb || ac !== ec) begin
            errors++;
            $display("FAIL %s: q_a=%h q_b=%h ctl=%b expected q_a=%h q_b=%h ctl=%b",
                     tag, q_a, q_b, ac, ea, eb, ec);
        end
    endtask

    // driver: apply on a falling edge, predict at the capturing rising edge
    task automatic step(string tag, logic fen, logic alt, logic cs0, logic cs1,
                        logic ck, logic od, logic [24:0] d);
        logic [13:0] grp;
        @(negedge clk);
        fanout_en = fen; alt_map = alt; csel_n = cs0; csel_aux_n = cs1;
        cke_in = ck; odt_in = od; din = d;
        @(posedge clk);
        grp = alt ? d[24:11] : d[13:0];
        if (cs0 && cs1) begin
            if (!fen) m_b = '0;
            else      m_a = {11'b0, m_a[13:0]};
        end else if (!fen) begin
            m_a = d; m_b = '0;
        end else begin
            m_a = {11'b0, grp}; m_b = grp;
        end
        m_ctl = fen ? {od, od, ck, ck} : {1'b0, od, 1'b0, ck};
        sb.push_back('{m_a, m_b, m_ctl, tag});
    endtask

    // asynchronous reset pulse across one rising edge, checked directly
    task automatic pulse_reset(string tag);
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1 compare(tag, '0, '0, '0);
        m_a = '0; m_b = '0; m_ctl = '0;
        @(negedge clk);
        compare(tag, '0, '0, '0);
        #2 rst_n = 1'b1;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                compare(it.tag, it.a, it.b, it.ctl);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2 rst_n = 1'b0;
        #1 compare("R1 reset state", '0, '0, '0);
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;

        // R11: zero data after release keeps outputs low
        step("R11 idle after release", 0, 0, 0, 0, 0, 0, 25'h0);
        step("R11 idle after release", 0, 0, 0, 0, 0, 0, 25'h0);

        // R2: 25-bit pass-through
        step("R2 wide pattern", 0, 0, 0, 0, 1, 0, 25'h1555555);
        step("R2 wide pattern", 0, 0, 0, 1, 0, 1, 25'h0AAAAAA);
        step("R2 wide pattern", 0, 0, 1, 0, 1, 1, 25'h1000001);

        // R3 / R10: two-copy mode, low group
        step("R3 pair low group", 1, 0, 0, 0, 1, 0, 25'h0002A5C);
        step("R3 pair low group", 1, 0, 0, 0, 0, 1, 25'h1FFFFFF);
        // R5: only the ignored upper inputs change
        step("R5 upper inputs ignored", 1, 0, 0, 0, 0, 1, 25'h0003FFF);
        step("R5 upper inputs ignored", 1, 0, 0, 0, 0, 1, 25'h1553FFF);

        // R4: two-copy mode, high group
        step("R4 pair high group", 1, 1, 0, 0, 1, 1, 25'h1234567);
        step("R4 pair high group", 1, 1, 0, 0, 1, 0, 25'h0FF8000);
        // R5: only the ignored low inputs change
        step("R5 low inputs ignored", 1, 1, 0, 0, 1, 0, 25'h0FF87FF);

        // R6 / R8: frozen data, control bits keep following
        step("R6 R8 frozen pair", 1, 1, 1, 1, 0, 1, 25'h0000000);
        step("R6 R8 frozen pair", 1, 1, 1, 1, 1, 0, 25'h1ABCDEF);
        // R7: one select low releases the freeze
        step("R7 csel_aux_n low", 1, 1, 1, 0, 1, 1, 25'h1ABCDEF);
        step("R7 csel_n low", 0, 0, 0, 1, 0, 0, 25'h0C0FFEE);
        step("R6 frozen wide", 0, 0, 1, 1, 1, 1, 25'h1111111);

        // R10: freeze across a change to two-copy mode
        step("R10 frozen mode change", 1, 0, 1, 1, 1, 0, 25'h0000000);
        step("R10 back to wide", 0, 0, 1, 1, 0, 1, 25'h1FFFFFF);

        // R9: reset wins over the freeze
        step("R9 load before reset", 0, 0, 0, 0, 1, 1, 25'h1F0F0F0);
        step("R9 freeze before reset", 0, 0, 1, 1, 1, 1, 25'h0000001);
        repeat (2) @(negedge clk);
        pulse_reset("R9 reset while frozen");
        step("R9 frozen after reset", 0, 0, 1, 1, 0, 0, 25'h1FFFFFF);
        step("R9 frozen after reset", 1, 1, 1, 1, 0, 0, 25'h1FFFFFF);

        // R11: first non-zero capture after the outputs were held low
        step("R11 first nonzero", 0, 0, 0, 0, 0, 0, 25'h0000080);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule